// File: doc/BRIEF.md
# Periodic Sampler with Host Interrupt Handshake

This block paces a repeating acquisition. It uses a timer that counts toward a deadline. When a deadline is reached, the block starts a conversion cycle. It requests a new input word from an analog-to-digital style port and, at the same moment, asks a digital-to-analog style port to take an output word. Each converter answers with a one-cycle acknowledge.

Once both transfers have finished, the block does three things:
- it holds the input word in a register the host can read;
- it raises an interrupt line;
- it stops and waits for the host.

The host reads the sample, computes a reply and clears the interrupt. The reply is latched at that moment. It goes out on the output port during the next cycle's write.

The period is counted from the previous deadline, not from the end of the previous cycle's work. Time spent on converter handshakes and host processing therefore comes out of the period and does not lengthen it. If a cycle's work runs past its deadline, no wait is added. The next cycle starts as soon as the interrupt is cleared, the schedule is re-based from that point, and a sticky overrun flag records the miss.

Top module: `tick_sampler`

## Requirements
- R1: While `rst` is high (synchronous, active high), and on the cycle after it falls, `irq`, `overrun`, `adc_req`, `dac_req`, `sample_q` and `dac_data` are all 0.
- R2: The first cycle starts on the PERIOD-th rising clock edge after the last edge on which `rst` was high. After that, whenever a cycle's work is done before its deadline, consecutive rising edges of `adc_req` are exactly PERIOD clock cycles apart, whatever the work time.
- R3: `adc_req` and `dac_req` rise on the same edge. Each one stays high until the cycle in which its own acknowledge is high, and falls on the following edge.
- R4: `irq` rises on the edge that follows the cycle in which the later of the two acknowledges is seen. `sample_q` then holds the `adc_data` value present with `adc_ack`.
- R5: While `irq` is high, neither request is raised, even after the deadline has passed. `irq` falls on the edge after a cycle in which `irq_clr` is high.
- R6: If the sequencer has not returned to waiting by the deadline cycle, the next cycle's requests rise on the second edge after the `irq_clr` cycle. The following deadline is re-based to PERIOD cycles after that start.
- R7: `overrun` is set whenever a deadline passes while a cycle's work is unfinished. It stays set until a cycle in which `ovr_clr` is high and no new overrun occurs, and then clears on the next edge.
- R8: `result_in` is latched when `irq_clr` clears the interrupt. It is presented on `dac_data`, and held stable, throughout the next cycle's output request. The first output after reset is 0.
- R9: An `irq_clr` pulse while `irq` is low has no effect: the latched result and the cycle timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_req | output | 1 | Request for a new input sample |
| adc_ack | input | 1 | Input sample valid, one-cycle pulse |
| adc_data | input | DATA_W | Input sample word |
| dac_req | output | 1 | Request to write the output word |
| dac_ack | input | 1 | Output word accepted, one-cycle pulse |
| dac_data | output | DATA_W | Output word (last host result) |
| irq | output | 1 | New sample available for the host |
| sample_q | output | DATA_W | Host-readable latest sample |
| irq_clr | input | 1 | Host clears the interrupt and supplies its result |
| result_in | input | DATA_W | Host-computed result word |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| overrun | output | 1 | Sticky deadline-miss flag |

## Verification
Five cycles are run, each with different converter latencies and host response times.

- **Work time.** In the first two cycles the input and output acknowledges arrive in opposite orders, and the host responds after a short delay. These cycles show whether the period is measured from the deadline, because the request spacing should stay at PERIOD while the work time varies.
- **Overrun.** In the third cycle the host holds the interrupt well past the deadline. This separates a fixed post-work delay from the immediate, re-based restart, and checks that the sticky flag sets and survives the next cycle.
- **Ignored clear.** A stray interrupt clear is sent while the sequencer is waiting, to confirm it leaves the latched result alone.
- **Result path.** Each host result is compared with the output word carried on the following write.

// File: rtl/tick_sampler_pkg.sv
package tick_sampler_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_IO   = 2'd1,
    ST_HOST = 2'd2
  } seq_state_t;
endpackage

// File: rtl/tick_period_timer.sv
module tick_period_timer #(
  parameter int PERIOD = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic ovr_clr,
  output logic tick,
  output logic overrun
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] remain;
  logic             due;

  assign due  = (remain == '0);
  assign tick = idle && due;

  // Deadline countdown: it saturates at zero, so an overrun leaves it there
  // until the sequencer is idle again, and the reload then re-bases the schedule.
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= RELOAD;
    end else if (tick) begin
      remain <= RELOAD;
    end else if (!due) begin
      remain <= remain - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun <= 1'b0;
    end else if (due && !idle) begin
      overrun <= 1'b1;
    end else if (ovr_clr) begin
      overrun <= 1'b0;
    end
  end

  AST_OVR_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(!idle)); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun && !ovr_clr |=> overrun); // R7
endmodule

// File: rtl/tick_io_seq.sv
module tick_io_seq
  import tick_sampler_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic adc_ack,
  input  logic dac_ack,
  input  logic irq_clr,
  output logic adc_req,
  output logic dac_req,
  output logic irq,
  output logic idle,
  output logic cap_en,
  output logic lat_en
);
  seq_state_t state;
  logic       adc_done;
  logic       dac_done;
  logic       adc_hit;
  logic       dac_hit;
  logic       both_done;

  assign adc_hit   = (state == ST_IO) && adc_req && adc_ack;
  assign dac_hit   = (state == ST_IO) && dac_req && dac_ack;
  assign both_done = (adc_done || adc_hit) && (dac_done || dac_hit);
  assign idle      = (state == ST_WAIT);
  assign cap_en    = adc_hit;
  assign lat_en    = (state == ST_HOST) && irq_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_WAIT;
      adc_req  <= 1'b0;
      dac_req  <= 1'b0;
      adc_done <= 1'b0;
      dac_done <= 1'b0;
      irq      <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (tick) begin
            adc_req  <= 1'b1;
            dac_req  <= 1'b1;
            adc_done <= 1'b0;
            dac_done <= 1'b0;
            state    <= ST_IO;
          end
        end
        ST_IO: begin
          if (adc_hit) begin
            adc_req  <= 1'b0;
            adc_done <= 1'b1;
          end
          if (dac_hit) begin
            dac_req  <= 1'b0;
            dac_done <= 1'b1;
          end
          if (both_done) begin
            irq   <= 1'b1;
            state <= ST_HOST;
          end
        end
        ST_HOST: begin
          if (irq_clr) begin
            irq   <= 1'b0;
            state <= ST_WAIT;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  AST_ADC_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    adc_req && !adc_ack |=> adc_req); // R3

  AST_DAC_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    dac_req && !dac_ack |=> dac_req); // R3

  AST_REQ_PAIRED: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_req) |-> $rose(dac_req)); // R3

  AST_IRQ_AFTER_IO: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(state == ST_IO)); // R4

  AST_QUIET_UNDER_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq |-> !adc_req && !dac_req); // R5
endmodule

// File: rtl/tick_host_regs.sv
module tick_host_regs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              lat_en,
  input  logic [DATA_W-1:0] result_in,
  output logic [DATA_W-1:0] sample_q,
  output logic [DATA_W-1:0] dac_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      dac_data <= '0;
    end else begin
      if (cap_en) sample_q <= adc_data;
      if (lat_en) dac_data <= result_in;
    end
  end
endmodule

// File: rtl/tick_sampler.sv
module tick_sampler #(
  parameter int PERIOD = 50_000_000,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              adc_req,
  input  logic              adc_ack,
  input  logic [DATA_W-1:0] adc_data,
  output logic              dac_req,
  input  logic              dac_ack,
  output logic [DATA_W-1:0] dac_data,
  output logic              irq,
  output logic [DATA_W-1:0] sample_q,
  input  logic              irq_clr,
  input  logic [DATA_W-1:0] result_in,
  input  logic              ovr_clr,
  output logic              overrun
);
  logic tick;
  logic idle;
  logic cap_en;
  logic lat_en;

  tick_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .idle    (idle),
    .ovr_clr (ovr_clr),
    .tick    (tick),
    .overrun (overrun)
  );

  tick_io_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .adc_ack (adc_ack),
    .dac_ack (dac_ack),
    .irq_clr (irq_clr),
    .adc_req (adc_req),
    .dac_req (dac_req),
    .irq     (irq),
    .idle    (idle),
    .cap_en  (cap_en),
    .lat_en  (lat_en)
  );

  tick_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .adc_data  (adc_data),
    .lat_en    (lat_en),
    .result_in (result_in),
    .sample_q  (sample_q),
    .dac_data  (dac_data)
  );

  AST_DAC_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    dac_req && $past(dac_req) |-> $stable(dac_data)); // R8

  AST_START_NEEDS_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_req) |-> $past(!irq)); // R5
endmodule

// File: tb/tick_sampler_test.sv
module tick_sampler_test;
  localparam int P  = 40;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adc_req, dac_req, irq, overrun;
  logic          adc_ack = 1'b0, dac_ack = 1'b0, irq_clr = 1'b0, ovr_clr = 1'b0;
  logic [DW-1:0] adc_data = '0, result_in = '0, dac_data, sample_q;

  int            n_cmp = 0;
  int            n_bad = 0;
  int            cyc = 0;
  logic [DW-1:0] exp_q[$];
  logic          irq_prev = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_sampler #(.PERIOD(P), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .adc_req(adc_req), .adc_ack(adc_ack), .adc_data(adc_data),
    .dac_req(dac_req), .dac_ack(dac_ack), .dac_data(dac_data), .irq(irq),
    .sample_q(sample_q), .irq_clr(irq_clr), .result_in(result_in),
    .ovr_clr(ovr_clr), .overrun(overrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // Scoreboard monitor: each interrupt rise must show the next expected sample
  always @(negedge clk) begin
    if (!rst && irq && !irq_prev) begin
      if (exp_q.size() == 0) check("R4 unexpected irq", 32'(irq), 32'h0);
      else check("R4 sample_q", 32'(sample_q), 32'(exp_q.pop_front()));
    end
    irq_prev = irq;
  end

  task automatic wait_req(output int waited, output int at);
    waited = 0;
    while (!adc_req) begin
      @(negedge clk);
      waited++;
    end
    at = cyc;
    check("R3 dac_req with adc_req", 32'(dac_req), 32'h1);
  endtask

  task automatic run_cycle(input logic [DW-1:0] av, input int la, input int dl,
                           input int hl, input logic [DW-1:0] res);
    exp_q.push_back(av);
    fork
      begin
        repeat (la) @(negedge clk);
        check("R3 adc_req held", 32'(adc_req), 32'h1);
        adc_data = av;
        adc_ack  = 1'b1;
        @(negedge clk);
        adc_ack  = 1'b0;
        check("R3 adc_req dropped", 32'(adc_req), 32'h0);
      end
      begin
        repeat (dl) @(negedge clk);
        check("R3 dac_req held", 32'(dac_req), 32'h1);
        dac_ack = 1'b1;
        @(negedge clk);
        dac_ack = 1'b0;
        check("R3 dac_req dropped", 32'(dac_req), 32'h0);
      end
    join
    check("R4 irq raised", 32'(irq), 32'h1);
    for (int i = 0; i < hl; i++) begin
      @(negedge clk);
      check("R5 no request under irq", 32'({adc_req, dac_req, irq}), 32'h1);
    end
    result_in = res;
    irq_clr   = 1'b1;
    @(negedge clk);
    irq_clr   = 1'b0;
    check("R5 irq cleared", 32'(irq), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w, t0, t1, base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", 32'({irq, overrun, adc_req, dac_req}), 32'h0);
    check("R1 reset sample_q", 32'(sample_q), 32'h0);
    check("R1 reset dac_data", 32'(dac_data), 32'h0);
    rst  = 1'b0;
    base = cyc;
    @(negedge clk);
    check("R1 after reset", 32'({irq, overrun, adc_req, dac_req}), 32'h0);

    wait_req(w, t0);
    check("R2 first start", 32'(t0 - base), 32'(P));
    check("R8 first output zero", 32'(dac_data), 32'h0);
    run_cycle(16'h1111, 2, 5, 3, 16'h00A1);

    // R9: stray clear while idle must be ignored
    @(negedge clk);
    result_in = 16'hDEAD;
    irq_clr   = 1'b1;
    @(negedge clk);
    irq_clr   = 1'b0;

    wait_req(w, t1);
    check("R2 period spacing 1", 32'(t1 - t0), 32'(P));
    check("R9 stray clear ignored", 32'(dac_data), 32'h00A1);
    check("R8 result on write", 32'(dac_data), 32'h00A1);
    t0 = t1;
    run_cycle(16'h2222, 6, 1, 4, 16'h00B2);

    wait_req(w, t1);
    check("R2 period spacing 2", 32'(t1 - t0), 32'(P));
    check("R8 result on write 2", 32'(dac_data), 32'h00B2);
    check("R7 no overrun yet", 32'(overrun), 32'h0);
    run_cycle(16'h3333, 1, 3, 50, 16'h00C3);
    check("R7 overrun set", 32'(overrun), 32'h1);

    wait_req(w, t0);
    check("R6 immediate restart", 32'(w), 32'h1);
    check("R8 result on write 3", 32'(dac_data), 32'h00C3);
    run_cycle(16'h4444, 2, 2, 2, 16'h00D4);
    check("R7 overrun sticky", 32'(overrun), 32'h1);

    @(negedge clk);
    ovr_clr = 1'b1;
    @(negedge clk);
    ovr_clr = 1'b0;
    check("R7 overrun cleared", 32'(overrun), 32'h0);

    wait_req(w, t1);
    check("R6 rebased spacing", 32'(t1 - t0), 32'(P));
    check("R8 result on write 4", 32'(dac_data), 32'h00D4);
    run_cycle(16'h5555, 3, 3, 1, 16'h00E5);
    check("R7 stays clear", 32'(overrun), 32'h0);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule